// File: doc/BRIEF.md
# Restart Opcode Call Sequencer

This block runs the call sequence that follows acceptance of a non-vectored interrupt. On a start pulse it raises an acknowledge strobe for one machine cycle and takes a one-byte restart opcode from the 8-bit data bus while the strobe is high. It then pushes the 16-bit return address onto the stack in two byte writes, one per machine cycle. Only after both writes does it present the new program-counter value, together with a one-clock done pulse.

A restart opcode carries a 3-bit code in its middle bits, and the target is that code times eight, so the targets run from 0x0000 to 0x0038. A byte that is not a restart opcode raises a one-clock error pulse. In that case the block makes no stack writes and gives no done pulse. The number of clocks in one machine cycle is the parameter `CYC_CLKS`.

Top module: `rst_call_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a start is accepted, `ack_o`, `stk_we_o`, `done_o` and `err_o` are all low.
- R2: A `start_i` seen high at a clock edge while the block is idle makes `ack_o` high from that edge for exactly `CYC_CLKS` clocks. This window is the first machine cycle.
- R3: The opcode is the value on `data_bus_i` at the last clock edge on which `ack_o` is high. Bus values after `ack_o` falls have no effect.
- R4: A byte with bits [7:6]=2'b11 and bits [2:0]=3'b111 is a restart opcode with code n = bits [5:3]. Its target is n×8, zero-extended to 16 bits.
- R5: A non-restart byte gives `err_o` high for one clock, in the clock right after the acknowledge cycle. There are then no stack writes, no `done_o`, and the block returns to idle.
- R6: For a restart opcode, the second machine cycle writes the return address high byte at SP−1, and the third writes the low byte at SP−2 (modulo 2^16). `stk_we_o` is high for exactly one clock in each of these cycles.
- R7: `done_o` is high for exactly one clock, in the clock after the third machine cycle, with `pc_o` holding the target. It never comes before both stack writes.
- R8: `start_i` is ignored while a sequence is in progress.
- R9: The return address and stack pointer are captured when the start is accepted. Later changes on `ret_addr_i` and `sp_i` do not alter the writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request from the interrupt accept logic |
| ret_addr_i | input | 16 | Address of the next instruction |
| data_bus_i | input | 8 | Data bus carrying the restart opcode |
| sp_i | input | 16 | Current stack pointer |
| ack_o | output | 1 | Interrupt acknowledge strobe |
| stk_addr_o | output | 16 | Stack write address |
| stk_data_o | output | 8 | Stack write data |
| stk_we_o | output | 1 | Stack write enable |
| pc_o | output | 16 | New program-counter value |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | One-clock pulse for a non-restart opcode |

## Verification
The bench drives every one of the eight restart codes, several near-miss bytes such as a call opcode and patterns that differ in a single bit, and a stack pointer of zero.

Each of these targets a specific design error:
- A decoder that checks too few bits would jump on a bad byte.
- A design that posts the pointer after writing, or swaps the byte order, would write the wrong address or data.
- A design that forgets the 16-bit wrap would write outside the top of memory.

The bench also does the following:
- It clears the bus as soon as the acknowledge window closes. This exposes a design that samples the opcode late.
- It pulses start and changes the return address and stack pointer partway through a sequence. This shows a design that restarts or uses live inputs.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PUSH_HI, S_PUSH_LO, S_DONE, S_ERR
  } rsq_state_e;

  function automatic logic rsq_is_restart(input logic [BYTE_W-1:0] op);
    return (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
  endfunction

  function automatic logic [WORD_W-1:0] rsq_target(input logic [BYTE_W-1:0] op);
    return {{(WORD_W-6){1'b0}}, op[5:3], 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] rsq_pre_dec(input logic [WORD_W-1:0] sp,
                                                    input logic [1:0] steps);
    return sp - {{(WORD_W-2){1'b0}}, steps};
  endfunction
endpackage

// File: rtl/rsq_cyc_timer.sv
module rsq_cyc_timer #(
  parameter int CYC_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int CW = (CYC_CLKS > 1) ? $clog2(CYC_CLKS) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(CYC_CLKS - 1);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == LAST_CNT);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || last) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rsq_decode.sv
module rsq_decode
  import rsq_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output logic              ok,
  output logic [WORD_W-1:0] target
);
  assign ok     = rsq_is_restart(op);
  assign target = rsq_target(op);
endmodule

// File: rtl/rsq_stack_port.sv
module rsq_stack_port
  import rsq_pkg::*;
(
  input  rsq_state_e        state,
  input  logic              cyc_last,
  input  logic [WORD_W-1:0] sp,
  input  logic [WORD_W-1:0] ret,
  output logic [WORD_W-1:0] addr,
  output logic [BYTE_W-1:0] data,
  output logic              we
);
  logic hi_cyc, lo_cyc;
  assign hi_cyc = (state == S_PUSH_HI);
  assign lo_cyc = (state == S_PUSH_LO);

  always_comb begin
    if (hi_cyc) begin
      addr = rsq_pre_dec(sp, 2'd1);
      data = ret[WORD_W-1:BYTE_W];
    end else begin
      addr = rsq_pre_dec(sp, 2'd2);
      data = ret[BYTE_W-1:0];
    end
  end

  assign we = (hi_cyc || lo_cyc) && cyc_last;
endmodule

// File: rtl/rst_call_seq.sv
module rst_call_seq
  import rsq_pkg::*;
#(
  parameter int CYC_CLKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] ret_addr_i,
  input  logic [BYTE_W-1:0] data_bus_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              ack_o,
  output logic [WORD_W-1:0] stk_addr_o,
  output logic [BYTE_W-1:0] stk_data_o,
  output logic              stk_we_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              done_o,
  output logic              err_o
);
  rsq_state_e state, state_nx;
  logic [WORD_W-1:0] ret_r, sp_r, pc_r;

  // named internal events
  logic in_cycle, cyc_last, fetch_last, op_ok, accept;
  logic [WORD_W-1:0] op_target;

  assign in_cycle   = (state == S_FETCH) || (state == S_PUSH_HI) || (state == S_PUSH_LO);
  assign accept     = (state == S_IDLE) && start_i;
  assign fetch_last = (state == S_FETCH) && cyc_last;

  rsq_cyc_timer #(.CYC_CLKS(CYC_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_cycle), .last(cyc_last)
  );

  rsq_decode u_dec (
    .op(data_bus_i), .ok(op_ok), .target(op_target)
  );

  rsq_stack_port u_stk (
    .state(state), .cyc_last(cyc_last), .sp(sp_r), .ret(ret_r),
    .addr(stk_addr_o), .data(stk_data_o), .we(stk_we_o)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:    if (start_i)  state_nx = S_FETCH;
      S_FETCH:   if (cyc_last) state_nx = op_ok ? S_PUSH_HI : S_ERR;
      S_PUSH_HI: if (cyc_last) state_nx = S_PUSH_LO;
      S_PUSH_LO: if (cyc_last) state_nx = S_DONE;
      S_DONE:    state_nx = S_IDLE;
      S_ERR:     state_nx = S_IDLE;
      default:   state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ret_r <= '0;
      sp_r  <= '0;
      pc_r  <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        ret_r <= ret_addr_i;
        sp_r  <= sp_i;
      end
      if (fetch_last && op_ok) pc_r <= op_target;
    end
  end

  assign ack_o  = (state == S_FETCH);
  assign done_o = (state == S_DONE);
  assign err_o  = (state == S_ERR);
  assign pc_o   = pc_r;
endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int WW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          ack_o,
  input logic          stk_we_o,
  input logic          done_o,
  input logic          err_o,
  input logic [WW-1:0] pc_o,
  input logic          fetch_last,
  input logic          op_ok
);
  logic [1:0] wcnt;

  always_ff @(posedge clk) begin
    if (!rst_n || ack_o)              wcnt <= '0;
    else if (stk_we_o && wcnt != 2'd3) wcnt <= wcnt + 1'b1;
  end

  assert_one_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_o, stk_we_o, done_o, err_o}));

  assert_ack_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(start_i));

  assert_err_after_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ($past(fetch_last) && !$past(op_ok)));

  assert_two_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (wcnt == 2'd2));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((pc_o & ~WW'(16'h0038)) == '0));
endmodule

bind rst_call_seq rsq_checker #(.WW(rsq_pkg::WORD_W)) u_rsq_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ack_o(ack_o),
  .stk_we_o(stk_we_o), .done_o(done_o), .err_o(err_o), .pc_o(pc_o),
  .fetch_last(fetch_last), .op_ok(op_ok)
);

// File: tb/tb_rst_call_seq.sv
`timescale 1ns/1ps
module tb_rst_call_seq;
  localparam int CYC = 3;
  localparam int NV  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [15:0] ret_addr_i = '0;
  logic [7:0]  data_bus_i = '0;
  logic [15:0] sp_i = '0;
  logic ack_o, stk_we_o, done_o, err_o;
  logic [15:0] stk_addr_o, pc_o;
  logic [7:0]  stk_data_o;

  always #4 clk = ~clk;

  rst_call_seq #(.CYC_CLKS(CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ret_addr_i(ret_addr_i),
    .data_bus_i(data_bus_i), .sp_i(sp_i), .ack_o(ack_o),
    .stk_addr_o(stk_addr_o), .stk_data_o(stk_data_o), .stk_we_o(stk_we_o),
    .pc_o(pc_o), .done_o(done_o), .err_o(err_o)
  );

  // {opcode, return address, stack pointer}
  localparam logic [39:0] VEC [NV] = '{
    {8'hC7, 16'h1234, 16'h2000}, {8'hCF, 16'hABCD, 16'hFFFF},
    {8'hD7, 16'h0100, 16'h8000}, {8'hDF, 16'h55AA, 16'h0002},
    {8'hE7, 16'hFFFF, 16'h1001}, {8'hEF, 16'h8001, 16'h4000},
    {8'hF7, 16'h0F0F, 16'h00FF}, {8'hFF, 16'h0001, 16'h0000},
    {8'hC6, 16'h1111, 16'h3000}, {8'hCD, 16'h2222, 16'h3000},
    {8'h47, 16'h3333, 16'h3000}, {8'h00, 16'h4444, 16'h3000}
  };

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [7:0] op, input logic [15:0] ret,
                         input logic [15:0] sp, input bit poke_start,
                         input bit poke_in, input string tag);
    bit good;
    logic [15:0] exp_pc;
    int ackn, wn, dn, en, didx, eidx, lastw, hidx;
    logic [15:0] wa [2];
    logic [7:0]  wd [2];
    logic [15:0] dpc;
    good   = (op[7:6] == 2'b11) && (op[2:0] == 3'b111);
    exp_pc = 16'(int'(op[5:3]) * 8);
    ackn = 0; wn = 0; dn = 0; en = 0; didx = -1; eidx = -1; lastw = -1; hidx = -1;
    wa[0] = '0; wa[1] = '0; wd[0] = '0; wd[1] = '0; dpc = '0;
    @(negedge clk);
    data_bus_i = op; ret_addr_i = ret; sp_i = sp; start_i = 1'b1;
    for (int k = 0; k < 3*CYC + 5; k++) begin
      @(negedge clk);
      if (k == 0) start_i = 1'b0;
      if (ack_o) begin ackn++; hidx = k; end
      else if (hidx >= 0) data_bus_i = 8'h00;   // bus cleared after acknowledge (R3)
      if (stk_we_o) begin
        if (wn < 2) begin wa[wn] = stk_addr_o; wd[wn] = stk_data_o; end
        wn++; lastw = k;
      end
      if (done_o) begin dn++; didx = k; dpc = pc_o; end
      if (err_o) begin en++; eidx = k; end
      if (poke_start && k == 4) start_i = 1'b1;
      if (poke_start && k == 5) start_i = 1'b0;
      if (poke_in && k == 1) begin ret_addr_i = ~ret; sp_i = sp + 16'h0100; end
    end
    chk(ackn == CYC && hidx == CYC-1, {"R2 ack window ", tag}, 32'(ackn), 32'(CYC));
    if (good) begin
      chk(wn == 2, {"R6 write count ", tag}, 32'(wn), 32'd2);
      chk(wa[0] == sp - 16'd1 && wd[0] == ret[15:8], {"R6 high byte ", tag},
          {wa[0], 8'h0, wd[0]}, {sp - 16'd1, 8'h0, ret[15:8]});
      chk(wa[1] == sp - 16'd2 && wd[1] == ret[7:0], {"R6 R9 low byte ", tag},
          {wa[1], 8'h0, wd[1]}, {sp - 16'd2, 8'h0, ret[7:0]});
      chk(dn == 1 && didx == 3*CYC && lastw < didx, {"R7 done timing ", tag},
          32'(didx), 32'(3*CYC));
      chk(dpc == exp_pc, {"R4 R3 target ", tag}, 32'(dpc), 32'(exp_pc));
      chk(en == 0, {"R5 no error on restart ", tag}, 32'(en), 32'd0);
    end else begin
      chk(en == 1 && eidx == CYC, {"R5 error pulse ", tag}, 32'(eidx), 32'(CYC));
      chk(wn == 0 && dn == 0, {"R5 no write no jump ", tag}, 32'(wn + dn), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!ack_o && !stk_we_o && !done_o && !err_o, "R1 outputs in reset",
        {ack_o, stk_we_o, done_o, err_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!ack_o && !stk_we_o && !done_o && !err_o, "R1 idle after reset",
        {ack_o, stk_we_o, done_o, err_o}, 0);

    for (int i = 0; i < NV; i++)
      run_one(VEC[i][39:32], VEC[i][31:16], VEC[i][15:0], 1'b0, 1'b0, $sformatf("vec%0d", i));

    // start pulse during a sequence (R8)
    run_one(8'hDF, 16'hBEEF, 16'h7000, 1'b1, 1'b0, "R8 start while busy");
    // inputs changed after acceptance (R9)
    run_one(8'hE7, 16'hC0DE, 16'h0400, 1'b0, 1'b1, "R9 late inputs");
    // reset in mid-sequence returns to idle (R1)
    @(negedge clk); data_bus_i = 8'hC7; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3*CYC + 2) @(negedge clk);
    chk(!ack_o && !stk_we_o && !done_o && !err_o, "R1 idle after mid reset",
        {ack_o, stk_we_o, done_o, err_o}, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule